// File: doc/BRIEF.md
# Ethernet PHY discovery and link bring-up sequencer

This block drives the power-up management sequence of an Ethernet transceiver through an MDIO frame master that it controls over a simple request/response port. After a `start` pulse it searches the 32 management addresses, from the lowest upward, for a device that answers. It takes the first one that answers and records its 32-bit identifier. It then soft-resets that device and waits for the reset to clear. Finally it enables and restarts auto-negotiation and waits for negotiation to finish.

Both waits are bounded polling loops. Successive reads in a loop are spaced by an interval timer of `TICK_CYCLES` clocks, which gives 10 ms at 50 MHz by default. The outcome is reported through a `done` level and a 2-bit status code. The code values are 0 for success, 1 for no device found, 2 for a reset that never cleared, and 3 for negotiation that never completed.

The FSM states are `S_IDLE`, `S_IDHI_REQ`, `S_IDHI_WAIT`, `S_IDLO_REQ`, `S_IDLO_WAIT`, `S_RST_WR`, `S_RST_WR_WAIT`, `S_RST_RD`, `S_RST_RD_WAIT`, `S_RST_PAUSE`, `S_AN_WR`, `S_AN_WR_WAIT`, `S_AN_RD`, `S_AN_RD_WAIT`, `S_AN_PAUSE` and `S_DONE`. Their transitions are as follows:
- `S_IDLE` or `S_DONE` moves to `S_IDHI_REQ` on `start`.
- Each `*_REQ`, `*_WR` or `*_RD` state moves to its `*_WAIT` state on `req_ready`.
- `S_IDHI_WAIT` moves back to `S_IDHI_REQ` when the read is all ones and the address is below 31. It moves to `S_DONE` (code 1) when the read is all ones at address 31. Otherwise it moves to `S_IDLO_REQ`.
- `S_IDLO_WAIT` moves to `S_RST_WR`.
- `S_RST_WR_WAIT` moves to `S_RST_RD`.
- `S_RST_RD_WAIT` moves to `S_AN_WR` once the reset bit is clear. It moves to `S_DONE` (code 2) when the budget is spent. Otherwise it moves to `S_RST_PAUSE`, and `S_RST_PAUSE` moves back to `S_RST_RD` when the timer expires.
- `S_AN_WR_WAIT` moves to `S_AN_RD`.
- `S_AN_RD_WAIT` moves to `S_DONE` with code 0 once negotiation is complete and with code 3 when the budget is spent. Otherwise it moves to `S_AN_PAUSE`, and `S_AN_PAUSE` moves back to `S_AN_RD` when the timer expires.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `done` is low and `req_valid` is low, and no transaction is issued until `start` is pulsed.
- R2: The scan reads register 2 (identifier high half) at addresses 0, 1, 2, … in ascending order. A read of 16'hFFFF marks the address as empty, and any other value marks it as occupied.
- R3: At the first occupied address the block reads register 3 (identifier low half) once and stops scanning. It presents that address on `phy_addr` and `{reg2, reg3}` on `phy_id`.
- R4: If all 32 addresses are empty, the block finishes with status 1 and issues no write and no register-3 read.
- R5: After the identifier is captured, the block writes 16'h8000 (reset bit 15 only) to register 0 of the found address.
- R6: The block reads register 0 until bit 15 reads 0. After `RESET_POLLS` reads with bit 15 still set, it finishes with status 2 and writes nothing more.
- R7: Once the reset has cleared, the block writes 16'h1200 (bit 12, negotiation enable, and bit 9, restart) to register 0 of the found address.
- R8: The block then reads register 1 until bit 5 is set and finishes with status 0. After `ANEG_POLLS` reads with bit 5 clear, it finishes with status 3.
- R9: `done` rises together with the status code. It holds with a stable status, address and identifier until the next `start`. A `start` while the sequence runs is ignored, and a `start` while `done` is high runs the whole sequence again.
- R10: A request holds `req_valid` and its fields steady until `req_ready`. Each transaction then waits for one `rsp_valid`.
- R11: Two consecutive poll reads in either loop are at least `TICK_CYCLES` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (accepted when idle or done) |
| req_valid | output | 1 | Management transaction request |
| req_ready | input | 1 | Master accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | Target device address |
| req_reg | output | 5 | Target register number |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Transaction completed (one-cycle pulse) |
| rsp_rdata | input | 16 | Read data, valid with `rsp_valid` |
| phy_addr | output | 5 | Address of the found device |
| phy_id | output | 32 | Identifier, high half from register 2 |
| done | output | 1 | Sequence finished; status is valid |
| status | output | 2 | 0 ok, 1 no device, 2 reset timeout, 3 link timeout |

## Verification
The two timeout exits are the hardest situations to reach from the ports, because a real device clears its reset and finishes negotiation long before any budget runs out. The bench sets `TICK_CYCLES`, `RESET_POLLS` and `ANEG_POLLS` to small values. Its behavioural device model can hold the reset bit set, or the negotiation-complete bit clear, for any number of reads, including more reads than the budget allows. The bench can therefore count the exact number of polls issued before each error code appears. It also measures the spacing between polls.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] LAST_ADDR  = 5'd31;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT   = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ID_HI  = 5'd2;
    localparam logic [ADDR_W-1:0] REG_ID_LO  = 5'd3;

    localparam logic [DATA_W-1:0] CTRL_SOFT_RESET = 16'h8000;
    localparam logic [DATA_W-1:0] CTRL_ANEG_GO    = 16'h1200;
    localparam logic [DATA_W-1:0] ABSENT_WORD     = 16'hFFFF;
    localparam int CTRL_RST_BIT   = 15;
    localparam int STAT_ANEG_BIT  = 5;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NO_PHY  = 2'd1,
        ST_RST_TO  = 2'd2,
        ST_LINK_TO = 2'd3
    } bring_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_IDHI_REQ, S_IDHI_WAIT, S_IDLO_REQ, S_IDLO_WAIT,
        S_RST_WR, S_RST_WR_WAIT, S_RST_RD, S_RST_RD_WAIT, S_RST_PAUSE,
        S_AN_WR, S_AN_WR_WAIT, S_AN_RD, S_AN_RD_WAIT, S_AN_PAUSE, S_DONE
    } seq_state_e;

endpackage

// File: rtl/bringup_interval.sv
module bringup_interval #(
    parameter int unsigned TICK_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TICK_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERMINAL = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == TERMINAL);

    // Counts while run is high; a dropped run or an expiry rearms it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bringup_poll_budget.sv
module bringup_poll_budget #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic exhausted
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] FINAL_IDX = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] used;

    // High while the poll in flight is the last one the budget allows.
    assign exhausted = (used == FINAL_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used <= '0;
        end else if (clear) begin
            used <= '0;
        end else if (bump && !exhausted) begin
            used <= used + 1'b1;
        end
    end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 500000,
    parameter int unsigned RESET_POLLS = 500,
    parameter int unsigned ANEG_POLLS  = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic [4:0]  req_phy,
    output logic [4:0]  req_reg,
    output logic [15:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [15:0] rsp_rdata,
    output logic [4:0]  phy_addr,
    output logic [31:0] phy_id,
    output logic        done,
    output logic [1:0]  status
);
    seq_state_e        state, state_nx;
    bring_status_e     status_q, status_nx;
    logic [ADDR_W-1:0] scan_addr;
    logic [DATA_W-1:0] id_hi, id_lo;

    logic tmr_run, tmr_expired;
    logic rst_clear, rst_bump, rst_last;
    logic an_clear, an_bump, an_last;

    logic id_absent, rst_busy, an_pending;
    assign id_absent  = (rsp_rdata == ABSENT_WORD);
    assign rst_busy   = rsp_rdata[CTRL_RST_BIT];
    assign an_pending = !rsp_rdata[STAT_ANEG_BIT];

    assign tmr_run   = (state == S_RST_PAUSE) || (state == S_AN_PAUSE);
    assign rst_clear = (state == S_RST_WR);
    assign rst_bump  = (state == S_RST_RD_WAIT) && rsp_valid && rst_busy;
    assign an_clear  = (state == S_AN_WR);
    assign an_bump   = (state == S_AN_RD_WAIT) && rsp_valid && an_pending;

    bringup_interval #(.TICK_CYCLES(TICK_CYCLES)) u_interval (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
    );

    bringup_poll_budget #(.LIMIT(RESET_POLLS)) u_rst_budget (
        .clk(clk), .rst_n(rst_n), .clear(rst_clear), .bump(rst_bump),
        .exhausted(rst_last)
    );

    bringup_poll_budget #(.LIMIT(ANEG_POLLS)) u_an_budget (
        .clk(clk), .rst_n(rst_n), .clear(an_clear), .bump(an_bump),
        .exhausted(an_last)
    );

    // State register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            status_q  <= ST_OK;
            scan_addr <= '0;
            id_hi     <= '0;
            id_lo     <= '0;
        end else begin
            state <= state_nx;
            if ((state == S_IDLE || state == S_DONE) && start) begin
                scan_addr <= '0;
                id_hi     <= '0;
                id_lo     <= '0;
            end
            if (state == S_IDHI_WAIT && rsp_valid) begin
                if (!id_absent) begin
                    id_hi <= rsp_rdata;
                end else if (scan_addr != LAST_ADDR) begin
                    scan_addr <= scan_addr + 1'b1;
                end
            end
            if (state == S_IDLO_WAIT && rsp_valid) begin
                id_lo <= rsp_rdata;
            end
            if (state_nx == S_DONE && state != S_DONE) begin
                status_q <= status_nx;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_nx  = state;
        status_nx = ST_OK;
        unique case (state)
            S_IDLE, S_DONE: if (start) state_nx = S_IDHI_REQ;
            S_IDHI_REQ:     if (req_ready) state_nx = S_IDHI_WAIT;
            S_IDHI_WAIT: if (rsp_valid) begin
                if (!id_absent) begin
                    state_nx = S_IDLO_REQ;
                end else if (scan_addr == LAST_ADDR) begin
                    state_nx  = S_DONE;
                    status_nx = ST_NO_PHY;
                end else begin
                    state_nx = S_IDHI_REQ;
                end
            end
            S_IDLO_REQ:     if (req_ready) state_nx = S_IDLO_WAIT;
            S_IDLO_WAIT:    if (rsp_valid) state_nx = S_RST_WR;
            S_RST_WR:       if (req_ready) state_nx = S_RST_WR_WAIT;
            S_RST_WR_WAIT:  if (rsp_valid) state_nx = S_RST_RD;
            S_RST_RD:       if (req_ready) state_nx = S_RST_RD_WAIT;
            S_RST_RD_WAIT: if (rsp_valid) begin
                if (!rst_busy) begin
                    state_nx = S_AN_WR;
                end else if (rst_last) begin
                    state_nx  = S_DONE;
                    status_nx = ST_RST_TO;
                end else begin
                    state_nx = S_RST_PAUSE;
                end
            end
            S_RST_PAUSE:    if (tmr_expired) state_nx = S_RST_RD;
            S_AN_WR:        if (req_ready) state_nx = S_AN_WR_WAIT;
            S_AN_WR_WAIT:   if (rsp_valid) state_nx = S_AN_RD;
            S_AN_RD:        if (req_ready) state_nx = S_AN_RD_WAIT;
            S_AN_RD_WAIT: if (rsp_valid) begin
                if (!an_pending) begin
                    state_nx  = S_DONE;
                    status_nx = ST_OK;
                end else if (an_last) begin
                    state_nx  = S_DONE;
                    status_nx = ST_LINK_TO;
                end else begin
                    state_nx = S_AN_PAUSE;
                end
            end
            S_AN_PAUSE:     if (tmr_expired) state_nx = S_AN_RD;
            default:        state_nx = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_reg   = REG_CTRL;
        req_wdata = '0;
        unique case (state)
            S_IDHI_REQ: begin req_valid = 1'b1; req_reg = REG_ID_HI; end
            S_IDLO_REQ: begin req_valid = 1'b1; req_reg = REG_ID_LO; end
            S_RST_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = CTRL_SOFT_RESET;
            end
            S_RST_RD:   begin req_valid = 1'b1; req_reg = REG_CTRL; end
            S_AN_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = CTRL_ANEG_GO;
            end
            S_AN_RD:    begin req_valid = 1'b1; req_reg = REG_STAT; end
            default:    req_valid = 1'b0;
        endcase
    end

    assign req_phy  = scan_addr;
    assign phy_addr = scan_addr;
    assign phy_id   = {id_hi, id_lo};
    assign done     = (state == S_DONE);
    assign status   = status_q;

endmodule

module phy_bringup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [4:0]  req_phy,
    input logic [4:0]  req_reg,
    input logic [15:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] phy_id,
    input logic        done,
    input logic [1:0]  status
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_write) &&
        $stable(req_phy) && $stable(req_reg) && $stable(req_wdata));

    // Covers R5 and R7: only the two control words are ever written.
    assert_write_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |->
        req_reg == 5'd0 && (req_wdata == 16'h8000 || req_wdata == 16'h1200));

    assert_read_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> req_reg <= 5'd3);

    assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rsp_valid));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(done) |-> $stable(status) && $stable(phy_id));
endmodule

bind phy_bringup_seq phy_bringup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .phy_id(phy_id),
    .done(done), .status(status)
);

// File: tb/phy_bringup_seq_test.sv
`timescale 1ns/1ps
module phy_bringup_seq_test;
    localparam int TB_TICK = 6;
    localparam int TB_RST  = 3;
    localparam int TB_AN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic req_valid, req_write;
    logic req_ready = 1'b0;
    logic [4:0] req_phy, req_reg;
    logic [15:0] req_wdata;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_rdata = '0;
    logic [4:0] phy_addr;
    logic [31:0] phy_id;
    logic done;
    logic [1:0] status;

    always #10 clk = ~clk;

    phy_bringup_seq #(.TICK_CYCLES(TB_TICK), .RESET_POLLS(TB_RST), .ANEG_POLLS(TB_AN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .phy_addr(phy_addr), .phy_id(phy_id), .done(done), .status(status)
    );

    // Device model configuration (written by the stimulus only)
    int          cfg_loc = -1;
    logic [15:0] cfg_hi = '0, cfg_lo = '0;
    int          cfg_rst_busy = 0, cfg_an_busy = 0;
    logic        clr_stats = 1'b0;

    // Model bookkeeping (written by the model only)
    int cyc = 0;
    int n_idhi, n_idlo, n_ctrl, n_stat, n_wr, scan_err, wr_addr_err, exp_scan;
    int rst_left, an_left, pend, last_ctrl, last_stat, gap_ctrl, gap_stat;
    logic [15:0] wr0, wr1, pend_data;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (clr_stats) begin
            n_idhi = 0; n_idlo = 0; n_ctrl = 0; n_stat = 0; n_wr = 0;
            scan_err = 0; wr_addr_err = 0; exp_scan = 0; pend = 0;
            rst_left = cfg_rst_busy; an_left = cfg_an_busy;
            last_ctrl = -1; last_stat = -1; gap_ctrl = 1000000; gap_stat = 1000000;
            wr0 = '0; wr1 = '0;
            req_ready <= 1'b0; rsp_valid <= 1'b0;
        end else begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= pend_data;
                end
            end else if (req_valid && !req_ready && !rsp_valid) begin
                req_ready <= 1'b1;
                pend = 3;
                pend_data = 16'hFFFF;
                if (req_write) begin
                    n_wr = n_wr + 1;
                    if (n_wr == 1) wr0 = req_wdata;
                    if (n_wr == 2) wr1 = req_wdata;
                    if (int'(req_phy) != cfg_loc) wr_addr_err = wr_addr_err + 1;
                    pend_data = 16'h0000;
                end else begin
                    if (req_reg == 5'd2) begin
                        n_idhi = n_idhi + 1;
                        if (int'(req_phy) != exp_scan) scan_err = scan_err + 1;
                        exp_scan = exp_scan + 1;
                    end
                    if (req_reg == 5'd3) n_idlo = n_idlo + 1;
                    if (int'(req_phy) == cfg_loc) begin
                        case (req_reg)
                            5'd2: pend_data = cfg_hi;
                            5'd3: pend_data = cfg_lo;
                            5'd0: begin
                                n_ctrl = n_ctrl + 1;
                                if (last_ctrl >= 0 && cyc - last_ctrl < gap_ctrl) gap_ctrl = cyc - last_ctrl;
                                last_ctrl = cyc;
                                if (rst_left > 0) begin
                                    rst_left = rst_left - 1;
                                    pend_data = 16'h9000;
                                end else pend_data = 16'h1000;
                            end
                            5'd1: begin
                                n_stat = n_stat + 1;
                                if (last_stat >= 0 && cyc - last_stat < gap_stat) gap_stat = cyc - last_stat;
                                last_stat = cyc;
                                if (an_left > 0) begin
                                    an_left = an_left - 1;
                                    pend_data = 16'h0009;
                                end else pend_data = 16'h0029;
                            end
                            default: pend_data = 16'h0000;
                        endcase
                    end
                end
            end
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic setup(input int loc, input logic [15:0] hi, input logic [15:0] lo,
                         input int rbusy, input int abusy);
        @(negedge clk);
        cfg_loc = loc; cfg_hi = hi; cfg_lo = lo;
        cfg_rst_busy = rbusy; cfg_an_busy = abusy;
        clr_stats = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        @(negedge clk);
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        chk(done, req, "done reached", longint'(done), 1);
    endtask

    // R1: quiet after reset
    task automatic t_reset();
        rst_n = 1'b0;
        setup(-1, 16'h0, 16'h0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        chk(req_valid == 1'b0, "R1", "req_valid after reset", longint'(req_valid), 0);
        chk(n_idhi == 0, "R1", "reads before start", n_idhi, 0);
    endtask

    // R2 R3 R5 R6 R7 R8 R9 R11: device at 5, short busy phases, stray start
    task automatic t_normal();
        setup(5, 16'h0022, 16'h1556, 1, 2);
        pulse_start();
        repeat (15) @(negedge clk);
        pulse_start();
        wait_done("R8");
        chk(status == 2'd0, "R8", "status ok", status, 0);
        chk(phy_addr == 5'd5, "R3", "phy_addr", phy_addr, 5);
        chk(phy_id == 32'h0022_1556, "R3", "phy_id", phy_id, 32'h0022_1556);
        chk(n_idhi == 6 && scan_err == 0, "R2", "ascending id reads", n_idhi, 6);
        chk(n_idlo == 1, "R3", "low half reads", n_idlo, 1);
        chk(wr0 == 16'h8000, "R5", "reset word", wr0, 16'h8000);
        chk(wr1 == 16'h1200, "R7", "negotiation word", wr1, 16'h1200);
        chk(n_wr == 2 && wr_addr_err == 0, "R5", "writes to found address", n_wr, 2);
        chk(n_ctrl == 2, "R6", "control polls", n_ctrl, 2);
        chk(n_stat == 3, "R8", "status polls", n_stat, 3);
        chk(gap_ctrl >= TB_TICK && gap_ctrl <= TB_TICK + 10, "R11", "control poll gap", gap_ctrl, TB_TICK);
        chk(gap_stat >= TB_TICK && gap_stat <= TB_TICK + 10, "R11", "status poll gap", gap_stat, TB_TICK);
        repeat (20) @(negedge clk);
        chk(done && status == 2'd0 && n_idhi == 6, "R9", "result held", n_idhi, 6);
    endtask

    // R2 R3 R9: device at 0 with an all-zero high half, restart from done
    task automatic t_first_addr();
        setup(0, 16'h0000, 16'hABCD, 0, 0);
        pulse_start();
        @(negedge clk);
        chk(done == 1'b0, "R9", "done drops on restart", longint'(done), 0);
        wait_done("R9");
        chk(status == 2'd0, "R9", "status after restart", status, 0);
        chk(phy_addr == 5'd0 && n_idhi == 1, "R2", "zero word counts as present", n_idhi, 1);
        chk(phy_id == 32'h0000_ABCD, "R3", "phy_id", phy_id, 32'h0000_ABCD);
        chk(n_ctrl == 1 && n_stat == 1, "R8", "single polls", n_ctrl + n_stat, 2);
    endtask

    // R4: nobody answers
    task automatic t_absent();
        setup(-1, 16'h0, 16'h0, 0, 0);
        pulse_start();
        wait_done("R4");
        chk(status == 2'd1, "R4", "no device code", status, 1);
        chk(n_idhi == 32 && scan_err == 0, "R4", "full scan", n_idhi, 32);
        chk(n_idlo == 0 && n_wr == 0, "R4", "no follow-up traffic", n_idlo + n_wr, 0);
    endtask

    // R6: reset never clears, device at the top address
    task automatic t_reset_stuck();
        setup(31, 16'h1234, 16'h5678, 100, 0);
        pulse_start();
        wait_done("R6");
        chk(status == 2'd2, "R6", "reset timeout code", status, 2);
        chk(n_ctrl == TB_RST, "R6", "control polls", n_ctrl, TB_RST);
        chk(n_wr == 1 && n_stat == 0, "R6", "no negotiation", n_wr, 1);
        chk(phy_addr == 5'd31, "R3", "top address", phy_addr, 31);
        chk(gap_ctrl >= TB_TICK, "R11", "control poll gap", gap_ctrl, TB_TICK);
    endtask

    // R8: negotiation never completes
    task automatic t_link_stuck();
        setup(9, 16'h0141, 16'h0CC2, 0, 100);
        pulse_start();
        wait_done("R8");
        chk(status == 2'd3, "R8", "link timeout code", status, 3);
        chk(n_stat == TB_AN, "R8", "status polls", n_stat, TB_AN);
        chk(n_wr == 2 && wr1 == 16'h1200, "R7", "negotiation written", wr1, 16'h1200);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_normal();
                t_first_addr();
                t_absent();
                t_reset_stuck();
                t_link_stuck();
            end
            begin
                repeat (150000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule